// File: doc/BRIEF.md
# I2C Controller Register Bank

This block is the processor-side register file of a byte-oriented I2C controller. It holds a control register, a status view and a data register on a small byte-wide register bus. It also generates the serial bit-rate tick from a 3-bit rate select. A separate protocol engine, which is not part of this block, takes the start, stop, acknowledge and enable controls and the outgoing byte from it. The engine returns state codes, event pulses, completion pulses, a shift-busy flag and received bytes.

Software writes the control register to request a start or stop condition, to pick a bit rate and to choose whether the controller acknowledges. When the engine reaches a state that needs attention, it pulses an event together with a 5-bit state code. The block then sets its interrupt flag and holds the code for software to read. Software clears the flag to let the engine go on. A low-power reset input returns every register to its reset value, and so does the chip reset.

Top module: `i2c_regbank`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xF8, the data register reads 0x00, and irq and all control outputs are 0.
- R2: Register addresses are 0 for control, 1 for status and 2 for data. A read strobe returns the addressed value on bus_rdata one clock later, and bus_rdata holds between strobes. Control bit positions: 7 rate bit 2, 6 enable, 5 start request, 4 stop request, 3 interrupt flag, 2 acknowledge enable, 1 rate bit 1, 0 rate bit 0. Enable, start and acknowledge enable drive enable, start_req and ack_en.
- R3: While enabled, rate_tick pulses for one cycle with a period in system clocks set by the rate code {bit7,bit1,bit0}: 000→256, 001→244, 010→192, 011→160, 100→960, 101→120, 110→60.
- R4: rate_tick never pulses while the rate code is 111 or the enable bit is 0.
- R5: Writing 1 to the stop bit sets it, and writing 0 to it has no effect. A pulse on eng_stop_done clears it.
- R6: The start bit follows software writes, and a pulse on eng_start_done clears it.
- R7: Writing 0 to the interrupt flag clears it, and writing 1 has no effect. A pulse on eng_event sets the flag and captures eng_status as the state code. An event in the same cycle as a software clear leaves the flag set.
- R8: The status register reads {code,3'b000} while the interrupt flag is 1 and reads 0xF8 while it is 0.
- R9: irq is 1 exactly when the interrupt flag is 1 and the held code is 25 or less.
- R10: Clearing the enable bit keeps the data register, the held state code and the other control bits.
- R11: A data write while eng_busy is 1 is ignored, and a data read while eng_busy is 1 returns 0x00. A pulse on eng_rx_valid loads eng_rx_byte into the data register.
- R12: A one-cycle pulse on lp_rst returns the control, status and data registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_rst | input | 1 | Low-power synchronous clear of all registers |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_rd |
| eng_status | input | 5 | State code from the protocol engine |
| eng_event | input | 1 | Engine event pulse; sets the interrupt flag |
| eng_start_done | input | 1 | Start condition issued |
| eng_stop_done | input | 1 | Stop condition sent |
| eng_busy | input | 1 | A byte is being shifted |
| eng_rx_valid | input | 1 | Received byte valid |
| eng_rx_byte | input | 8 | Received byte |
| start_req | output | 1 | Start request to engine |
| stop_req | output | 1 | Stop request to engine |
| ack_en | output | 1 | Acknowledge enable |
| enable | output | 1 | Controller enable |
| rate_tick | output | 1 | Bit-rate tick |
| tx_byte | output | 8 | Data register contents |
| irq | output | 1 | Interrupt request |

## Verification
A register write, an event pulse or a done pulse changes the register at the next rising edge. The control outputs and irq therefore show the new value at the falling edge that follows, and the bench samples them there. A read result appears one edge after the strobe. The driver queues the expected byte when it raises bus_rd, and the monitor pops and compares it at the next falling edge. Tick periods are measured between two successive ticks, so the phase of the counter after a rate change does not matter.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int CODE_W = 5;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [AW-1:0] ADDR_DATA = 2'd2;

  localparam logic [CODE_W-1:0] CODE_IDLE    = 5'd31;
  localparam logic [CODE_W-1:0] CODE_IRQ_MAX = 5'd25;
  localparam logic [2:0]        RATE_RSVD    = 3'b111;

  typedef struct packed {
    logic r2;
    logic en;
    logic sta;
    logic sto;
    logic si;
    logic aa;
    logic r1;
    logic r0;
  } ctrl_t;

  function automatic int unsigned rate_div(input logic [2:0] sel);
    case (sel)
      3'b000:  rate_div = 256;
      3'b001:  rate_div = 244;
      3'b010:  rate_div = 192;
      3'b011:  rate_div = 160;
      3'b100:  rate_div = 960;
      3'b101:  rate_div = 120;
      3'b110:  rate_div = 60;
      default: rate_div = 0;
    endcase
  endfunction
endpackage

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_rst,
  input  logic              wr_ctrl,
  input  logic [DW-1:0]     wdata,
  input  logic              ev_set,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              start_done,
  input  logic              stop_done,
  output ctrl_t             ctrl_q,
  output logic [CODE_W-1:0] code_q,
  output logic              irq
);
  ctrl_t             ctrl_n;
  logic [CODE_W-1:0] code_n;

  always_comb begin
    ctrl_n = ctrl_q;
    code_n = code_q;
    if (start_done) ctrl_n.sta = 1'b0;
    if (stop_done)  ctrl_n.sto = 1'b0;
    if (wr_ctrl) begin
      ctrl_n.r2  = wdata[7];
      ctrl_n.en  = wdata[6];
      ctrl_n.sta = wdata[5];
      if (wdata[4])  ctrl_n.sto = 1'b1;
      if (!wdata[3]) ctrl_n.si  = 1'b0;
      ctrl_n.aa  = wdata[2];
      ctrl_n.r1  = wdata[1];
      ctrl_n.r0  = wdata[0];
    end
    if (ev_set) begin
      ctrl_n.si = 1'b1;
      code_n    = ev_code;
    end
    if (lp_rst) begin
      ctrl_n = '0;
      code_n = CODE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      code_q <= CODE_IDLE;
    end else begin
      ctrl_q <= ctrl_n;
      code_q <= code_n;
    end
  end

  assign irq = ctrl_q.si && (code_q <= CODE_IRQ_MAX);
endmodule

// File: rtl/i2cr_rate.sv
module i2cr_rate
  import i2cr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_rst,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] lim;
  logic             run, wrap, tick_n;

  assign lim    = CNT_W'(rate_div(sel) - 1);
  assign run    = en && (sel != RATE_RSVD);
  assign wrap   = run && (cnt_q >= lim);
  assign tick_n = wrap && !lp_rst;

  always_comb begin
    cnt_n = cnt_q;
    if (run) cnt_n = wrap ? '0 : cnt_q + 1'b1;
    if (lp_rst) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tick  <= tick_n;
    end
  end
endmodule

// File: rtl/i2cr_data.sv
module i2cr_data
  import i2cr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_rst,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] data_n;

  always_comb begin
    data_n = data_q;
    if (rx_valid)             data_n = rx_byte;
    else if (wr_data && !busy) data_n = wdata;
    if (lp_rst) data_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_n;
  end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
  import i2cr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [CODE_W-1:0] eng_status,
  input  logic              eng_event,
  input  logic              eng_start_done,
  input  logic              eng_stop_done,
  input  logic              eng_busy,
  input  logic              eng_rx_valid,
  input  logic [DW-1:0]     eng_rx_byte,
  output logic              start_req,
  output logic              stop_req,
  output logic              ack_en,
  output logic              enable,
  output logic              rate_tick,
  output logic [DW-1:0]     tx_byte,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  ctrl_t             ctrl_q;
  logic [CODE_W-1:0] code_q;
  logic [DW-1:0]     data_q;
  logic [DW-1:0]     stat_view, rd_mux, rdata_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  i2cr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .lp_rst(lp_rst),
    .wr_ctrl(bus_wr && bus_addr == ADDR_CTRL), .wdata(bus_wdata),
    .ev_set(eng_event), .ev_code(eng_status),
    .start_done(eng_start_done), .stop_done(eng_stop_done),
    .ctrl_q(ctrl_q), .code_q(code_q), .irq(irq)
  );

  i2cr_rate #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n_s), .lp_rst(lp_rst), .en(ctrl_q.en),
    .sel({ctrl_q.r2, ctrl_q.r1, ctrl_q.r0}), .tick(rate_tick)
  );

  i2cr_data u_data (
    .clk(clk), .rst_n(rst_n_s), .lp_rst(lp_rst),
    .wr_data(bus_wr && bus_addr == ADDR_DATA), .wdata(bus_wdata),
    .busy(eng_busy), .rx_valid(eng_rx_valid), .rx_byte(eng_rx_byte),
    .data_q(data_q)
  );

  assign stat_view = ctrl_q.si ? {code_q, 3'b000} : {CODE_IDLE, 3'b000};

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: rd_mux = ctrl_q;
      ADDR_STAT: rd_mux = stat_view;
      ADDR_DATA: rd_mux = eng_busy ? '0 : data_q;
      default:   rd_mux = '0;
    endcase
    rdata_n = bus_rd ? rd_mux : bus_rdata;
    if (lp_rst) rdata_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) bus_rdata <= '0;
    else          bus_rdata <= rdata_n;
  end

  assign start_req = ctrl_q.sta;
  assign stop_req  = ctrl_q.sto;
  assign ack_en    = ctrl_q.aa;
  assign enable    = ctrl_q.en;
  assign tx_byte   = data_q;
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
  import i2cr_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              lp_rst,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              eng_event,
  input logic              eng_stop_done,
  input logic              eng_busy,
  input logic              eng_rx_valid,
  input logic              rate_tick,
  input logic              irq,
  input logic              stop_req,
  input logic [DW-1:0]     tx_byte,
  input logic [DW-1:0]     ctrl_q
);
  // R5
  sto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_CTRL && !bus_wdata[4] && stop_req && !eng_stop_done && !lp_rst)
    |=> stop_req);

  // R7
  si_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_CTRL && bus_wdata[3] && !ctrl_q[3] && !eng_event)
    |=> !ctrl_q[3]);

  // R9
  irq_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> $past(eng_event));

  // R4
  no_tick_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((ctrl_q[7] && ctrl_q[1] && ctrl_q[0]) || !ctrl_q[6]) |=> !rate_tick);

  // R11
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_DATA && eng_busy && !eng_rx_valid && !lp_rst)
    |=> $stable(tx_byte));

  // R12
  lp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lp_rst |=> (ctrl_q == 8'h00 && tx_byte == 8'h00 && !irq));
endmodule

bind i2c_regbank i2cr_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .lp_rst(lp_rst),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .eng_event(eng_event), .eng_stop_done(eng_stop_done), .eng_busy(eng_busy),
  .eng_rx_valid(eng_rx_valid), .rate_tick(rate_tick), .irq(irq),
  .stop_req(stop_req), .tx_byte(tx_byte), .ctrl_q(ctrl_q)
);

// File: tb/sim_i2c_regbank.sv
module sim_i2c_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_rst = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] eng_status = '0;
  logic       eng_event = 1'b0, eng_start_done = 1'b0, eng_stop_done = 1'b0;
  logic       eng_busy = 1'b0, eng_rx_valid = 1'b0;
  logic [7:0] eng_rx_byte = '0;
  logic       start_req, stop_req, ack_en, enable, rate_tick, irq;
  logic [7:0] tx_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #10 clk = ~clk;

  i2c_regbank u0 (
    .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_status(eng_status), .eng_event(eng_event),
    .eng_start_done(eng_start_done), .eng_stop_done(eng_stop_done),
    .eng_busy(eng_busy), .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
    .start_req(start_req), .stop_req(stop_req), .ack_en(ack_en),
    .enable(enable), .rate_tick(rate_tick), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one edge after the strobe
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 1, 0);
      else chk(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ev(input logic [4:0] code);
    @(negedge clk); eng_status = code; eng_event = 1'b1;
    @(negedge clk); eng_event = 1'b0;
  endtask

  task automatic period(input int exp, input string tag);
    int n = 0;
    int guard = 0;
    while (!rate_tick && guard < 3000) begin @(negedge clk); guard++; end
    @(negedge clk); n = 1;
    while (!rate_tick && n < 3000) begin @(negedge clk); n++; end
    chk(tag, n, exp);
  endtask

  task automatic no_ticks(input string tag);
    int cnt = 0;
    repeat (1100) begin @(negedge clk); if (rate_tick) cnt++; end
    chk(tag, cnt, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 irq", int'(irq), 0);
    chk("R1 start_req", int'(start_req), 0);
    chk("R1 enable", int'(enable), 0);
    rd(2'd0, 8'h00, "R1 ctrl reset");
    rd(2'd1, 8'hF8, "R1 status reset");
    rd(2'd2, 8'h00, "R1 data reset");
    // R2 layout and outputs
    wr(2'd0, 8'h24);
    chk("R2 start_req", int'(start_req), 1);
    chk("R2 ack_en", int'(ack_en), 1);
    chk("R2 enable", int'(enable), 0);
    rd(2'd0, 8'h24, "R2 ctrl readback");
    // R6 start cleared by engine
    @(negedge clk); eng_start_done = 1'b1;
    @(negedge clk); eng_start_done = 1'b0;
    chk("R6 start cleared", int'(start_req), 0);
    rd(2'd0, 8'h04, "R6 ctrl after start");
    // R5 stop write-one only
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h10, "R5 stop set");
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h10, "R5 stop write 0 ignored");
    chk("R5 stop_req held", int'(stop_req), 1);
    @(negedge clk); eng_stop_done = 1'b1;
    @(negedge clk); eng_stop_done = 1'b0;
    rd(2'd0, 8'h00, "R5 stop cleared by engine");
    // R7 R8 R9 interrupt flag
    ev(5'd3);
    chk("R9 irq code 3", int'(irq), 1);
    rd(2'd0, 8'h08, "R7 flag set by event");
    rd(2'd1, 8'h18, "R8 status code 3");
    wr(2'd0, 8'h08);
    rd(2'd0, 8'h08, "R7 write 1 no effect");
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h00, "R7 write 0 clears");
    rd(2'd1, 8'hF8, "R8 idle when flag clear");
    chk("R9 irq after clear", int'(irq), 0);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1;
    eng_status = 5'd25; eng_event = 1'b1;
    @(negedge clk); bus_wr = 1'b0; eng_event = 1'b0;
    chk("R7 event beats clear", int'(irq), 1);
    rd(2'd1, 8'hC8, "R8 status code 25");
    wr(2'd0, 8'h00);
    ev(5'd26);
    chk("R9 irq code 26", int'(irq), 0);
    rd(2'd1, 8'hD0, "R8 status code 26");
    ev(5'd31);
    chk("R9 irq code 31", int'(irq), 0);
    rd(2'd1, 8'hF8, "R8 status code 31");
    wr(2'd0, 8'h00);
    // R11 data register
    wr(2'd2, 8'h5A);
    rd(2'd2, 8'h5A, "R11 data write idle");
    eng_busy = 1'b1;
    wr(2'd2, 8'h11);
    chk("R11 tx_byte kept while busy", int'(tx_byte), 8'h5A);
    rd(2'd2, 8'h00, "R11 read while busy");
    eng_busy = 1'b0;
    rd(2'd2, 8'h5A, "R11 busy write ignored");
    @(negedge clk); eng_rx_byte = 8'hA5; eng_rx_valid = 1'b1;
    @(negedge clk); eng_rx_valid = 1'b0;
    rd(2'd2, 8'hA5, "R11 received byte");
    wr(2'd2, 8'h5A);
    // R10 disable keeps state
    wr(2'd0, 8'h44);
    ev(5'd3);
    wr(2'd0, 8'h0C);
    chk("R10 enable off", int'(enable), 0);
    rd(2'd2, 8'h5A, "R10 data kept");
    rd(2'd1, 8'h18, "R10 code kept");
    rd(2'd0, 8'h0C, "R10 ctrl bits kept");
    // R12 low-power reset
    wr(2'd0, 8'h74);
    ev(5'd4);
    @(negedge clk); lp_rst = 1'b1;
    @(negedge clk); lp_rst = 1'b0;
    chk("R12 irq", int'(irq), 0);
    chk("R12 stop_req", int'(stop_req), 0);
    rd(2'd0, 8'h00, "R12 ctrl");
    rd(2'd1, 8'hF8, "R12 status");
    rd(2'd2, 8'h00, "R12 data");
    // R3 tick periods
    wr(2'd0, 8'hC2);
    period(60, "R3 period code 110");
    wr(2'd0, 8'h40);
    period(256, "R3 period code 000");
    wr(2'd0, 8'hC1);
    period(120, "R3 period code 101");
    wr(2'd0, 8'h43);
    period(160, "R3 period code 011");
    // R4 no ticks
    wr(2'd0, 8'hC3);
    @(negedge clk);
    no_ticks("R4 reserved code");
    wr(2'd0, 8'h82);
    @(negedge clk);
    no_ticks("R4 disabled");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule